// File: doc/BRIEF.md
# Transaction Ordering Arbiter

This block decides which of four queue heads may next drive a shared internal bus. The queues are an inbound posted-write queue, an outbound read-completion queue, an inbound read-request queue and an inbound configuration-write queue. Each queue presents only its head: a valid flag and an arrival stamp. All stamps come from one free-running counter that every queue shares. Storing the queue contents and running the bus protocol are handled outside this block.

Selection happens in two stages. First, a fixed pass/no-pass matrix compares arrival stamps and removes any head that is not yet allowed to move. Second, a round-robin picker chooses among the heads that are left. The chosen head receives a registered one-hot grant. That grant works as a valid signal, and `bus_done` works as the matching ready. The grant stays high and unchanged until `bus_done` is seen. In the cycle where both are high, `pop` names the queue to dequeue. A `bus_done` that arrives with no grant is ignored. While a grant is outstanding, no other grant can be issued.

Top module: `txn_order_arbiter`

## Requirements
- R1: After reset, `grant`, `pop` and `busy` are zero, and the round-robin pointer is at the posted-write queue (bit 0). With all four heads valid and equal stamps, the first grant therefore goes to bit 0.
- R2: `grant` is one-hot or zero. A grant is given only to a queue whose head is valid. Bit order is 0 posted write, 1 read completion, 2 read request, 3 configuration write.
- R3: A valid posted-write head with a strictly older stamp blocks the read-completion, read-request and configuration-write heads.
- R4: A posted-write head is never blocked, including by an older read completion. Between an eligible posted write and an eligible read completion, only the round-robin decides.
- R5: A read-request head is blocked while a valid configuration-write head has a strictly older stamp. A younger or same-stamp configuration write does not block it.
- R6: Among the eligible heads, the winner is the first one found scanning upward, with wrap, from the pointer. After a grant on queue k, the pointer moves to k+1 mod 4.
- R7: Stamp x counts as older than stamp y when (y - x) mod 2^STAMP_W is nonzero and below 2^(STAMP_W-1). This comparison stays correct across counter wrap.
- R8: A grant is registered on the clock edge after an idle cycle that has an eligible head. It then holds steady, with `busy` high, until `bus_done` is sampled. On the edge after that, `grant` and `busy` both return to zero.
- R9: `pop` equals `grant` during a cycle where `bus_done` is high. A `bus_done` pulse while idle gives `pop` = 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 4 | Head valid per queue (bit 0 posted write, 1 read completion, 2 read request, 3 config write) |
| pw_stamp | input | STAMP_W | Arrival stamp of the posted-write head |
| rc_stamp | input | STAMP_W | Arrival stamp of the read-completion head |
| rr_stamp | input | STAMP_W | Arrival stamp of the read-request head |
| cw_stamp | input | STAMP_W | Arrival stamp of the configuration-write head |
| bus_done | input | 1 | Bus-side completion; acts as ready for the held grant |
| grant | output | 4 | One-hot grant, held until completion |
| busy | output | 1 | A granted transaction is in flight |
| pop | output | 4 | Dequeue strobe for the granted queue |

## Verification
The assertions rely on three assumptions about the inputs. A granted head keeps its valid flag and stamp until `bus_done`. The stamps of all pending heads lie within half the counter range of each other. A queue changes its head only after a pop. The stimulus respects all three. Every scenario holds its inputs fixed from the moment of issue until completion. Stamps are a base value plus offsets of 0 to 3 on a 4-bit counter, and some base values force a wrap.

// File: rtl/ordarb_pkg.sv
package ordarb_pkg;
  localparam int unsigned NQ  = 4;
  localparam int unsigned QIW = 2;

  typedef enum logic [QIW-1:0] {
    Q_PW = 2'd0,
    Q_RC = 2'd1,
    Q_RR = 2'd2,
    Q_CW = 2'd3
  } qid_e;

  typedef logic [NQ-1:0] qmask_t;
endpackage

// File: rtl/ordarb_age_cmp.sv
module ordarb_age_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] stamp_a,
  input  logic [W-1:0] stamp_b,
  output logic         a_older
);
  logic [W-1:0] gap;

  always_comb begin
    gap     = stamp_b - stamp_a;
    a_older = (gap != '0) && !gap[W-1];
  end
endmodule

// File: rtl/ordarb_elig.sv
module ordarb_elig
  import ordarb_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  qmask_t          valid_i,
  input  logic [NQ*W-1:0] stamps_i,
  output qmask_t          elig_o
);
  logic [W-1:0] st [NQ];
  qmask_t       pw_older;
  logic         cw_older_rr;

  for (genvar q = 0; q < NQ; q++) begin : g_unpack
    assign st[q] = stamps_i[q*W +: W];
  end

  // posted write against each other queue head
  assign pw_older[0] = 1'b0;
  for (genvar q = 1; q < NQ; q++) begin : g_pw_cmp
    ordarb_age_cmp #(.W(W)) u_cmp (
      .stamp_a (st[Q_PW]),
      .stamp_b (st[q]),
      .a_older (pw_older[q])
    );
  end

  ordarb_age_cmp #(.W(W)) u_cw_rr (
    .stamp_a (st[Q_CW]),
    .stamp_b (st[Q_RR]),
    .a_older (cw_older_rr)
  );

  always_comb begin
    elig_o = valid_i;
    for (int q = 1; q < NQ; q++) begin
      if (valid_i[Q_PW] && pw_older[q]) elig_o[q] = 1'b0;
    end
    if (valid_i[Q_CW] && cw_older_rr) elig_o[Q_RR] = 1'b0;
  end
endmodule

// File: rtl/ordarb_rr.sv
module ordarb_rr #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic [N-1:0]  pick_o,
  output logic [IW-1:0] pick_idx_o,
  output logic          any_o
);
  always_comb begin
    logic found;
    int   idx;
    found      = 1'b0;
    pick_o     = '0;
    pick_idx_o = '0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_i) + k;
      if (idx >= int'(N)) idx = idx - int'(N);
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        pick_o     = '0;
        pick_o[idx] = 1'b1;
        pick_idx_o = IW'(idx);
      end
    end
    any_o = found;
  end

  // R2
  rr_pick_onehot_chk: assert final ($onehot0(pick_o));
endmodule

// File: rtl/txn_order_arbiter.sv
module txn_order_arbiter
  import ordarb_pkg::*;
#(
  parameter int unsigned STAMP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         head_valid,
  input  logic [STAMP_W-1:0] pw_stamp,
  input  logic [STAMP_W-1:0] rc_stamp,
  input  logic [STAMP_W-1:0] rr_stamp,
  input  logic [STAMP_W-1:0] cw_stamp,
  input  logic               bus_done,
  output logic [3:0]         grant,
  output logic               busy,
  output logic [3:0]         pop
);
  localparam int unsigned SW = NQ * STAMP_W;

  logic [SW-1:0]  stamps;
  qmask_t         elig;
  qmask_t         pick;
  logic [QIW-1:0] pick_idx;
  logic           any_elig;
  logic [QIW-1:0] ptr_q;
  qmask_t         gnt_q;
  logic           busy_q;
  logic           issue;

  assign stamps = {cw_stamp, rr_stamp, rc_stamp, pw_stamp};

  ordarb_elig #(.W(STAMP_W)) u_elig (
    .valid_i  (head_valid),
    .stamps_i (stamps),
    .elig_o   (elig)
  );

  ordarb_rr #(.N(NQ)) u_rr (
    .req_i      (elig),
    .ptr_i      (ptr_q),
    .pick_o     (pick),
    .pick_idx_o (pick_idx),
    .any_o      (any_elig)
  );

  assign issue = !busy_q && any_elig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
      ptr_q  <= QIW'(Q_PW);
    end else if (issue) begin
      gnt_q  <= pick;
      busy_q <= 1'b1;
      ptr_q  <= pick_idx + QIW'(1);
    end else if (busy_q && bus_done) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
    end
  end

  assign grant = gnt_q;
  assign busy  = busy_q;
  assign pop   = gnt_q & {NQ{bus_done}};

  function automatic logic older_f(input logic [STAMP_W-1:0] a,
                                   input logic [STAMP_W-1:0] b);
    logic [STAMP_W-1:0] d;
    d = b - a;
    return (d != '0) && (d < (STAMP_W'(1) << (STAMP_W - 1)));
  endfunction

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((grant & head_valid) != '0));

  // R3
  rc_behind_pw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant[1]) |-> !($past(head_valid[0]) && older_f($past(pw_stamp), $past(rc_stamp))));

  // R3
  rr_behind_pw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant[2]) |-> !($past(head_valid[0]) && older_f($past(pw_stamp), $past(rr_stamp))));

  // R3
  cw_behind_pw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant[3]) |-> !($past(head_valid[0]) && older_f($past(pw_stamp), $past(cw_stamp))));

  // R5
  rr_behind_cw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant[2]) |-> !($past(head_valid[3]) && older_f($past(cw_stamp), $past(rr_stamp))));

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_done) |=> (busy && $stable(grant)));

  // R8
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_done) |=> (grant == '0 && !busy));

  // R9
  pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pop == '0));
endmodule

// File: tb/txn_order_arbiter_bench.sv
module txn_order_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    head_valid = '0;
  logic [SW-1:0] pw_stamp = '0, rc_stamp = '0, rr_stamp = '0, cw_stamp = '0;
  logic          bus_done = 1'b0;
  logic [3:0]    grant, pop;
  logic          busy;

  int total = 0;
  int bad = 0;
  int ptr = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_order_arbiter #(.STAMP_W(SW)) u_txn_order_arbiter (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid),
    .pw_stamp(pw_stamp), .rc_stamp(rc_stamp), .rr_stamp(rr_stamp), .cw_stamp(cw_stamp),
    .bus_done(bus_done), .grant(grant), .busy(busy), .pop(pop)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input int m, input int code, input int base);
    int off [4];
    bit v [4];
    bit e [4];
    int exp_g;
    int k_win;
    for (int q = 0; q < 4; q++) begin
      off[q] = (code >> (2*q)) & 3;
      v[q]   = m[q];
    end
    head_valid = m[3:0];
    pw_stamp = SW'((base + off[0]) % 16);   // R7: base near 15 wraps
    rc_stamp = SW'((base + off[1]) % 16);
    rr_stamp = SW'((base + off[2]) % 16);
    cw_stamp = SW'((base + off[3]) % 16);
    // eligibility from the rules, using unwrapped offsets
    e[0] = v[0];                                              // R4
    for (int q = 1; q < 4; q++) e[q] = v[q] && !(v[0] && off[0] < off[q]); // R3
    if (v[3] && off[3] < off[2]) e[2] = 1'b0;                 // R5
    exp_g = 0;
    k_win = -1;
    for (int k = 0; k < 4; k++) begin                         // R6
      int idx;
      idx = (ptr + k) % 4;
      if (k_win < 0 && e[idx]) k_win = idx;
    end
    if (k_win >= 0) exp_g = 1 << k_win;
    @(posedge clk);
    @(negedge clk);
    chk(grant == 4'(exp_g), "R3/R4/R5/R6/R7 grant", grant, exp_g);
    if (exp_g != 0) begin
      chk(busy == 1'b1, "R8 busy", busy, 1);
      repeat (2) @(negedge clk);
      chk(grant == 4'(exp_g), "R8 hold", grant, exp_g);
      bus_done = 1'b1;
      #1;
      chk(pop == 4'(exp_g), "R9 pop", pop, exp_g);
      @(negedge clk);
      bus_done = 1'b0;
      chk(grant == 4'd0 && !busy, "R8 release", {busy, grant}, 0);
      ptr = (k_win + 1) % 4;
    end else begin
      bus_done = 1'b1;                                       // R9 idle done
      #1;
      chk(pop == 4'd0, "R9 idle pop", pop, 0);
      @(negedge clk);
      bus_done = 1'b0;
      chk(grant == 4'd0 && !busy, "R2 no grant", {busy, grant}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(grant == 4'd0 && pop == 4'd0 && !busy, "R1 reset", {busy, pop, grant}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 all valid, equal stamps: pointer starts at bit 0
    run_case(15, 0, 5);
    chk(ptr == 1, "R1 first winner", ptr, 1);
    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 16; m++) begin
        for (int c = 0; c < 256; c++) begin
          run_case(m, c, (b == 0) ? 3 : 14);
        end
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule